// File: doc/BRIEF.md
# JTAG Test Access Port with Memory-Access Instructions

This block is a serial test access port that a debug host drives over TCK, TMS and TDI. It uses the usual sixteen-state controller and a 3-bit instruction register. There is no boundary-scan chain. IDCODE and BYPASS work as usual. Five private instructions turn data-register scans into operations on a memory port:

- setting the address,
- writing a data word,
- reading a data word,
- requesting a reboot,
- requesting a save.

The memory, its backing store and any flash programming sit outside this block.

The whole block runs on TCK with a synchronous active-high reset. TDO and its enable are driven from the falling edge. Every memory-side output is a register. A second host interface may own the memory at times. While its `host_busy` input is high, the block emits no memory strobe. A scan can still complete, and it still updates the address and data holding registers.

Top module: `jtag_mem_tap`

## Requirements
- R1: During and right after reset, every strobe and pulse is low and `mem_addr` and `mem_wdata` are zero. `tdo_en` is low and the controller sits in Test-Logic-Reset with IDCODE (000) selected. A data scan then shifts out the 32-bit ID, LSB first.
- R2: Five consecutive TCK rising edges with TMS high put the controller in Test-Logic-Reset from any state. This selects IDCODE again.
- R3: The instruction register is 3 bits wide with these encodings: IDCODE=000, LOAD_ADDR=001, WRITE_DATA=010, READ_DATA=011, REBOOT=100, SAVE=101, BYPASS=111 (110 behaves as BYPASS). Capture-IR loads 001. The register shifts LSB first and takes effect in Update-IR.
- R4: Under BYPASS the data path is one stage that captures 0. A shifted pattern therefore comes out delayed by one bit, with a leading 0.
- R5: Under LOAD_ADDR the data register is AW bits wide and Capture-DR loads the current `mem_addr`. `mem_addr` takes the shifted value on the edge into Update-DR.
- R6: Under WRITE_DATA the data register is DW bits wide. On the edge into Update-DR, `mem_wdata` takes the shifted value. `mem_wr` is high for exactly the one Update-DR cycle.
- R7: Under READ_DATA, `mem_rd` is high for the one Select-DR-Scan cycle. Capture-DR, one cycle later, loads `mem_rdata`, and the following DW-bit shift returns it LSB first.
- R8: Under REBOOT or SAVE the data register is one bit. On the edge into Update-DR, `reboot_pulse` or `save_pulse` respectively goes high for one cycle. No two of `mem_wr`, `mem_rd`, `reboot_pulse` and `save_pulse` are high together.
- R9: If `host_busy` is high on the edge that would raise `mem_wr`, `mem_rd`, `reboot_pulse` or `save_pulse`, that strobe stays low. The memory keeps its contents.
- R10: TDO and `tdo_en` change on the falling edge of TCK. `tdo_en` is high only while the controller is in Shift-DR or Shift-IR.
- R11: TMS low in Exit1-DR leads to Pause-DR. A scan that pauses and resumes through Exit2-DR produces the same result as an uninterrupted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select driving the controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| host_busy | input | 1 | Other interface owns the memory; blocks strobes |
| mem_addr | output | AW | Memory address register |
| mem_wdata | output | DW | Memory write data register |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` |
| reboot_pulse | output | 1 | One-cycle reboot request |
| save_pulse | output | 1 | One-cycle save request |

## Verification
The write strobe and the lockout can meet on the same edge: the one that moves the controller into Update-DR under WRITE_DATA. The bench provokes this by holding `host_busy` high across a write scan. It judges the result by seeing `mem_wr` low in Update-DR, `mem_wdata` still loaded, and a later read returning the old memory word. The same overlap is exercised for READ_DATA, whose strobe edge is the entry to Select-DR-Scan, and for REBOOT.

// File: rtl/jtag_mem_pkg.sv
`timescale 1ns/1ps
package jtag_mem_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [IR_W-1:0] {
    OP_IDCODE = 3'b000,
    OP_LDADDR = 3'b001,
    OP_WRDATA = 3'b010,
    OP_RDDATA = 3'b011,
    OP_REBOOT = 3'b100,
    OP_SAVE   = 3'b101,
    OP_RSVD   = 3'b110,
    OP_BYPASS = 3'b111
  } tap_op_t;
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import jtag_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t st,
  output tap_state_t nx
);
  always_comb begin
    unique case (st)
      ST_TLR:      nx = tms ? ST_TLR      : ST_RTI;
      ST_RTI:      nx = tms ? ST_SEL_DR   : ST_RTI;
      ST_SEL_DR:   nx = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nx = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: nx = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: nx = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nx = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: nx = tms ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   nx = tms ? ST_SEL_DR   : ST_RTI;
      ST_SEL_IR:   nx = tms ? ST_TLR      : ST_CAP_IR;
      ST_CAP_IR:   nx = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: nx = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: nx = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nx = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: nx = tms ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   nx = tms ? ST_SEL_DR   : ST_RTI;
      default:     nx = ST_TLR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_TLR;
    else     st <= nx;
  end
endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import jtag_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  tap_state_t st,
  input  logic       tdi,
  output tap_op_t    op,
  output logic       ir_lsb
);
  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_sr <= '0;
      op    <= OP_IDCODE;
    end else begin
      case (st)
        ST_TLR:      op    <= OP_IDCODE;
        ST_CAP_IR:   ir_sr <= IR_W'(1);
        ST_SHIFT_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        ST_UPD_IR:   op    <= tap_op_t'(ir_sr);
        default: ;
      endcase
    end
  end

  assign ir_lsb = ir_sr[0];
endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
  import jtag_mem_pkg::*;
#(
  parameter int          AW      = 8,
  parameter int          DW      = 16,
  parameter int          DRW     = 32,
  parameter logic [31:0] ID_CODE = 32'h1A5E_0001
) (
  input  logic           clk,
  input  logic           rst,
  input  tap_state_t     st,
  input  tap_op_t        op,
  input  logic           tdi,
  input  logic [AW-1:0]  cur_addr,
  input  logic [DW-1:0]  rdata,
  output logic [DRW-1:0] sr,
  output logic           dr_lsb
);
  int             len;
  logic [DRW-1:0] pos, cap_val, nsr;

  // active length of the selected register
  always_comb begin
    case (op)
      OP_IDCODE:            len = 32;
      OP_LDADDR:            len = AW;
      OP_WRDATA, OP_RDDATA: len = DW;
      default:              len = 1;
    endcase
  end

  always_comb begin
    case (op)
      OP_IDCODE: cap_val = DRW'(ID_CODE);
      OP_LDADDR: cap_val = DRW'(cur_addr);
      OP_RDDATA: cap_val = DRW'(rdata);
      OP_WRDATA: cap_val = sr;
      default:   cap_val = '0;
    endcase
  end

  assign pos = DRW'(1) << (len - 1);
  assign nsr = ((sr >> 1) & ~pos) | ({DRW{tdi}} & pos);

  always_ff @(posedge clk) begin
    if (rst)                    sr <= '0;
    else if (st == ST_CAP_DR)   sr <= cap_val;
    else if (st == ST_SHIFT_DR) sr <= nsr;
  end

  assign dr_lsb = sr[0];
endmodule

// File: rtl/tap_memport.sv
`timescale 1ns/1ps
module tap_memport
  import jtag_mem_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  tap_state_t    nx,
  input  tap_op_t       op,
  input  logic [AW-1:0] sr_addr,
  input  logic [DW-1:0] sr_data,
  input  logic          host_busy,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic          reboot_pulse,
  output logic          save_pulse
);
  logic upd, go;
  assign upd = (nx == ST_UPD_DR);
  assign go  = !host_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_wr       <= 1'b0;
      mem_rd       <= 1'b0;
      reboot_pulse <= 1'b0;
      save_pulse   <= 1'b0;
    end else begin
      mem_wr       <= 1'b0;
      reboot_pulse <= 1'b0;
      save_pulse   <= 1'b0;
      mem_rd       <= (nx == ST_SEL_DR) && (op == OP_RDDATA) && go;
      if (upd) begin
        case (op)
          OP_LDADDR: mem_addr <= sr_addr;
          OP_WRDATA: begin
            mem_wdata <= sr_data;
            mem_wr    <= go;
          end
          OP_REBOOT: reboot_pulse <= go;
          OP_SAVE:   save_pulse   <= go;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/jtag_mem_tap.sv
`timescale 1ns/1ps
module jtag_mem_tap
  import jtag_mem_pkg::*;
#(
  parameter int          AW      = 8,
  parameter int          DW      = 16,
  parameter logic [31:0] ID_CODE = 32'h1A5E_0001
) (
  input  logic          tck,
  input  logic          rst,
  input  logic          tms,
  input  logic          tdi,
  output logic          tdo,
  output logic          tdo_en,
  input  logic          host_busy,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          reboot_pulse,
  output logic          save_pulse
);
  localparam int WMAX = (AW > DW) ? AW : DW;
  localparam int DRW  = (WMAX > 32) ? WMAX : 32;

  tap_state_t     st, nx;
  tap_op_t        op;
  logic           ir_lsb, dr_lsb;
  logic [DRW-1:0] dr_sr;

  tap_fsm u_fsm (.clk(tck), .rst(rst), .tms(tms), .st(st), .nx(nx));

  tap_ir u_ir (.clk(tck), .rst(rst), .st(st), .tdi(tdi), .op(op), .ir_lsb(ir_lsb));

  tap_dr #(.AW(AW), .DW(DW), .DRW(DRW), .ID_CODE(ID_CODE)) u_dr (
    .clk(tck), .rst(rst), .st(st), .op(op), .tdi(tdi),
    .cur_addr(mem_addr), .rdata(mem_rdata), .sr(dr_sr), .dr_lsb(dr_lsb)
  );

  tap_memport #(.AW(AW), .DW(DW)) u_mp (
    .clk(tck), .rst(rst), .nx(nx), .op(op),
    .sr_addr(dr_sr[AW-1:0]), .sr_data(dr_sr[DW-1:0]), .host_busy(host_busy),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .reboot_pulse(reboot_pulse), .save_pulse(save_pulse)
  );

  // serial output launched on the falling edge
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (st == ST_SHIFT_DR) || (st == ST_SHIFT_IR);
      tdo    <= (st == ST_SHIFT_IR) ? ir_lsb : dr_lsb;
    end
  end
endmodule

// File: rtl/jtag_mem_tap_chk.sv
`timescale 1ns/1ps
module jtag_mem_tap_chk
  import jtag_mem_pkg::*;
(
  input logic       tck,
  input logic       rst,
  input logic       tms,
  input logic       host_busy,
  input logic       tdo_en,
  input logic       mem_wr,
  input logic       mem_rd,
  input logic       reboot_pulse,
  input logic       save_pulse,
  input tap_state_t st
);
  logic [2:0] hi_cnt;
  always_ff @(posedge tck) begin
    if (rst)      hi_cnt <= '0;
    else if (!tms) hi_cnt <= '0;
    else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge tck)
    rst |=> (!mem_wr && !mem_rd && !reboot_pulse && !save_pulse));

  assert_tms_reset_R2: assert property (@(posedge tck) disable iff (rst)
    (hi_cnt >= 3'd5) |-> (st == ST_TLR));

  assert_wr_single_R6: assert property (@(posedge tck) disable iff (rst)
    mem_wr |=> !mem_wr);

  assert_rd_single_R7: assert property (@(posedge tck) disable iff (rst)
    mem_rd |=> !mem_rd);

  assert_strobe_excl_R8: assert property (@(posedge tck) disable iff (rst)
    $onehot0({mem_wr, mem_rd, reboot_pulse, save_pulse}));

  assert_lockout_R9: assert property (@(posedge tck) disable iff (rst)
    (mem_wr || mem_rd || reboot_pulse || save_pulse) |-> !$past(host_busy));

  assert_tdo_window_R10: assert property (@(posedge tck) disable iff (rst)
    tdo_en |-> (st == ST_SHIFT_DR || st == ST_SHIFT_IR));
endmodule

bind jtag_mem_tap jtag_mem_tap_chk u_chk (
  .tck(tck), .rst(rst), .tms(tms), .host_busy(host_busy), .tdo_en(tdo_en),
  .mem_wr(mem_wr), .mem_rd(mem_rd), .reboot_pulse(reboot_pulse),
  .save_pulse(save_pulse), .st(st)
);

// File: tb/tb_jtag_mem_tap.sv
`timescale 1ns/1ps
module tb_jtag_mem_tap;
  localparam int          AW = 8;
  localparam int          DW = 16;
  localparam logic [31:0] ID = 32'h1A5E_0001;

  logic tck = 0, rst = 1, tms = 1, tdi = 0, host_busy = 0;
  logic tdo, tdo_en, mem_wr, mem_rd, reboot_pulse, save_pulse;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int checks = 0, errors = 0;

  always #2.5 tck = ~tck;

  jtag_mem_tap #(.AW(AW), .DW(DW), .ID_CODE(ID)) dut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .host_busy(host_busy), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .reboot_pulse(reboot_pulse), .save_pulse(save_pulse)
  );

  // memory model with one cycle read latency
  logic [DW-1:0] mem [256];
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem_rdata = '0;
  end
  always @(posedge tck) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  // stimulus / expected table: {address, data}
  localparam logic [23:0] VEC [4] = '{
    {8'h01, 16'h1234}, {8'h7F, 16'hBEEF}, {8'hFF, 16'h0001}, {8'h80, 16'hFFFF}
  };

  logic last_tdo, last_en, en_ok, sel_rd, upd_wr, upd_rb, upd_sv, post_wr;
  logic [DW-1:0] upd_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic d);
    tms = t; tdi = d;
    @(negedge tck); #1;
    last_tdo = tdo; last_en = tdo_en;
    @(posedge tck); #1;
  endtask

  task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i]);
      cap[i] = last_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, input int pause_at,
                         output logic [31:0] dout);
    dout = '0;
    en_ok = 1;
    step(1, 0); sel_rd = mem_rd;
    step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step((i == n - 1) || (i == pause_at - 1), din[i]);
      dout[i] = last_tdo;
      if (!last_en) en_ok = 0;
      if (i == pause_at - 1 && i != n - 1) begin
        step(0, 0); step(0, 0); step(1, 0); step(0, 0);
      end
    end
    step(1, 0);
    upd_wr = mem_wr; upd_rb = reboot_pulse; upd_sv = save_pulse; upd_wdata = mem_wdata;
    step(0, 0);
    post_wr = mem_wr;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0]  cap;
    logic [31:0] dout;

    repeat (4) @(posedge tck);
    #1;
    chk(!mem_wr && !mem_rd && !reboot_pulse && !save_pulse, "R1 strobes in reset",
        {mem_wr, mem_rd, reboot_pulse, save_pulse}, 0);
    chk(mem_addr == 0 && mem_wdata == 0, "R1 registers in reset", {mem_addr, mem_wdata}, 0);
    rst = 0;
    step(0, 0);
    chk(!last_en, "R10 tdo_en low outside shift", last_en, 0);
    scan_dr(32, 0, 0, dout);
    chk(dout == ID, "R1 IDCODE after reset", dout, ID);
    chk(en_ok, "R10 tdo_en high in Shift-DR", en_ok, 1);

    scan_ir(3'b111, cap);
    chk(cap == 3'b001, "R3 Capture-IR value", cap, 3'b001);
    scan_dr(8, 32'hB2, 0, dout);
    chk(dout[7:0] == 8'h64, "R4 bypass one-bit delay", dout[7:0], 8'h64);
    scan_ir(3'b110, cap);
    scan_dr(4, 32'hF, 0, dout);
    chk(dout[3:0] == 4'hE, "R4 unused code acts as bypass", dout[3:0], 4'hE);

    scan_ir(3'b001, cap);
    scan_dr(AW, 32'h3C, 0, dout);
    chk(mem_addr == 8'h3C, "R5 address update", mem_addr, 8'h3C);
    scan_dr(AW, 32'h5A, 0, dout);
    chk(dout[7:0] == 8'h3C, "R5 capture of current address", dout[7:0], 8'h3C);
    scan_dr(AW, 32'hA7, 3, dout);
    chk(mem_addr == 8'hA7, "R11 scan through Pause-DR", mem_addr, 8'hA7);
    chk(dout[7:0] == 8'h5A, "R11 capture before pause", dout[7:0], 8'h5A);

    for (int v = 0; v < 4; v++) begin
      scan_ir(3'b001, cap);
      scan_dr(AW, 32'(VEC[v][23:16]), 0, dout);
      scan_ir(3'b010, cap);
      scan_dr(DW, 32'(VEC[v][15:0]), 0, dout);
      chk(upd_wr && upd_wdata == VEC[v][15:0], "R6 write strobe in Update-DR",
          {upd_wr, upd_wdata}, {1'b1, VEC[v][15:0]});
      chk(!post_wr, "R6 write strobe one cycle", post_wr, 0);
      chk(mem[VEC[v][23:16]] == VEC[v][15:0], "R6 memory written",
          mem[VEC[v][23:16]], VEC[v][15:0]);
    end
    for (int v = 0; v < 4; v++) begin
      scan_ir(3'b001, cap);
      scan_dr(AW, 32'(VEC[v][23:16]), 0, dout);
      scan_ir(3'b011, cap);
      scan_dr(DW, 0, 0, dout);
      chk(sel_rd, "R7 read strobe in Select-DR-Scan", sel_rd, 1);
      chk(dout[15:0] == VEC[v][15:0], "R7 read data shifted out", dout[15:0], VEC[v][15:0]);
    end

    scan_ir(3'b100, cap);
    scan_dr(1, 0, 0, dout);
    chk(upd_rb && !upd_sv && !upd_wr, "R8 reboot pulse", {upd_rb, upd_sv, upd_wr}, 3'b100);
    scan_ir(3'b101, cap);
    scan_dr(1, 0, 0, dout);
    chk(upd_sv && !upd_rb, "R8 save pulse", {upd_sv, upd_rb}, 2'b10);

    // lockout coinciding with each strobe edge
    scan_ir(3'b001, cap);
    scan_dr(AW, 32'h7F, 0, dout);
    scan_ir(3'b010, cap);
    host_busy = 1;
    scan_dr(DW, 32'hDEAD, 0, dout);
    chk(!upd_wr, "R9 write blocked", upd_wr, 0);
    chk(upd_wdata == 16'hDEAD, "R9 data still latched", upd_wdata, 16'hDEAD);
    chk(mem[8'h7F] == 16'hBEEF, "R9 memory unchanged", mem[8'h7F], 16'hBEEF);
    scan_ir(3'b011, cap);
    scan_dr(DW, 0, 0, dout);
    chk(!sel_rd, "R9 read blocked", sel_rd, 0);
    scan_ir(3'b100, cap);
    scan_dr(1, 0, 0, dout);
    chk(!upd_rb, "R9 reboot blocked", upd_rb, 0);
    host_busy = 0;
    scan_ir(3'b011, cap);
    scan_dr(DW, 0, 0, dout);
    chk(dout[15:0] == 16'hBEEF, "R9 old word read back", dout[15:0], 16'hBEEF);

    // five TMS-high edges from inside Shift-DR
    scan_ir(3'b111, cap);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);
    for (int k = 0; k < 5; k++) step(1, 0);
    step(0, 0);
    scan_dr(32, 0, 0, dout);
    chk(dout == ID, "R2 TMS reset restores IDCODE", dout, ID);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule